// File: doc/BRIEF.md
# Receive Condition Status Byte

This block keeps one channel's special receive condition flags in a read-only status byte and raises the matching interrupt request. The receiver sends it single-cycle event strobes: a frame closed on a valid flag, a CRC or framing error, an overrun, a parity error, and the first character of a new frame. A frame-close strobe comes with a residue value, which counts the leftover bits of the last information character. The transmitter supplies an idle indication that becomes the all-sent flag.

The flags are sticky. They stay set until an error-reset command, a channel reset or a hardware reset clears them. The end-of-frame flag means something only in bit-oriented framed mode. While it is set, the CRC/framing flag and the residue field are valid for the frame that has just closed. The next frame's first character clears the end-of-frame flag and the residue.

Top module: `rx_cond_status`

## Requirements
- R1: The status byte `status_o` has this layout: bit 7 end of frame, bit 6 CRC/framing error, bit 5 overrun, bit 4 parity error, bits 3..1 residue (bit 3 is the residue MSB), bit 0 all sent.
- R2: A low `rst_n` (asynchronous) or a high `chan_reset_i` at a clock edge puts the status byte at 8'h01 and drops `src_irq_o`.
- R3: In framed mode (`mode_i` = 2'b10), `eof_evt_i` sets bit 7 and loads `residue_i` into bits 3..1 at the same edge. In any other mode `eof_evt_i` changes neither field.
- R4: Bit 7 reads 0 whenever `mode_i` is not 2'b10. The stored flag is kept and shows again once framed mode returns.
- R5: `err_reset_i` clears bits 7..4 at the next edge and leaves the residue and all-sent bits alone. A set event in the same cycle wins over the clear for its own bit.
- R6: `new_frame_i` clears bit 7 and the residue at the next edge and leaves bits 6..4 alone. A framed-mode `eof_evt_i` in the same cycle wins.
- R7: `crc_err_evt_i`, `overrun_evt_i` and `parity_evt_i` set bits 6, 5 and 4. Each bit stays set until a clear from R2 or R5.
- R8: `src_irq_o` is high in the same cycle exactly when `rx_int_en_i` is high and any of the status bits 7..4, as read, is set.
- R9: At each edge bit 0 takes the value of `tx_idle_i` when `mode_i` = 2'b00 (character mode), and 1 in the other modes (2'b01, 2'b10, 2'b11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| mode_i | input | 2 | 00 character, 01 sync-character, 10 framed, 11 external sync |
| rx_int_en_i | input | 1 | Receive interrupt enable |
| eof_evt_i | input | 1 | Valid closing flag seen |
| crc_err_evt_i | input | 1 | CRC or framing error |
| overrun_evt_i | input | 1 | Receive overrun |
| parity_evt_i | input | 1 | Parity error |
| new_frame_i | input | 1 | First character of a following frame |
| residue_i | input | RES_W | Residue value delivered with eof_evt_i |
| tx_idle_i | input | 1 | Transmitter idle |
| err_reset_i | input | 1 | Error-reset command |
| chan_reset_i | input | 1 | Channel reset command, synchronous |
| status_o | output | RES_W+5 | Status byte |
| src_irq_o | output | 1 | Special receive condition interrupt request |

## Verification
The bench uses the default RES_W of 3. This gives the 8-bit byte with its fixed bit positions and lets random frame closes reach all eight residue values. The stimulus switches between all four modes while end-of-frame is held, so the bench sees the masking and the stored flag showing again. It also places set events on the same cycle as error-reset, new-frame and channel-reset commands to exercise the priority rules.

// File: rtl/rx_cond_status.sv
module rx_cond_status #(
  parameter int RES_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             rx_int_en_i,
  input  logic             eof_evt_i,
  input  logic             crc_err_evt_i,
  input  logic             overrun_evt_i,
  input  logic             parity_evt_i,
  input  logic             new_frame_i,
  input  logic [RES_W-1:0] residue_i,
  input  logic             tx_idle_i,
  input  logic             err_reset_i,
  input  logic             chan_reset_i,
  output logic [RES_W+4:0] status_o,
  output logic             src_irq_o
);
  localparam int STAT_W = RES_W + 5;
  localparam logic [1:0] MODE_CHAR   = 2'b00;
  localparam logic [1:0] MODE_FRAMED = 2'b10;

  logic             eof_q, crc_q, ovr_q, par_q, sent_q;
  logic [RES_W-1:0] res_q;
  logic             framed, eof_take;

  assign framed   = (mode_i == MODE_FRAMED);
  assign eof_take = framed && eof_evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eof_q <= 1'b0; crc_q <= 1'b0; ovr_q <= 1'b0; par_q <= 1'b0;
      res_q <= '0;   sent_q <= 1'b1;
    end else if (chan_reset_i) begin
      eof_q <= 1'b0; crc_q <= 1'b0; ovr_q <= 1'b0; par_q <= 1'b0;
      res_q <= '0;   sent_q <= 1'b1;
    end else begin
      if (eof_take) begin
        eof_q <= 1'b1;
        res_q <= residue_i;
      end else begin
        if (new_frame_i || err_reset_i) eof_q <= 1'b0;
        if (new_frame_i) res_q <= '0;
      end
      crc_q  <= crc_err_evt_i || (crc_q && !err_reset_i);
      ovr_q  <= overrun_evt_i || (ovr_q && !err_reset_i);
      par_q  <= parity_evt_i  || (par_q && !err_reset_i);
      sent_q <= (mode_i == MODE_CHAR) ? tx_idle_i : 1'b1;
    end
  end

  assign status_o  = {eof_q && framed, crc_q, ovr_q, par_q, res_q, sent_q};
  assign src_irq_o = rx_int_en_i && (|status_o[STAT_W-1 -: 4]);

  // R2
  chan_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_reset_i |=> (status_o == STAT_W'(1)) && !src_irq_o);

  // R3
  eof_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_take && !chan_reset_i) |=> (!framed || status_o[STAT_W-1]));

  // R5
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reset_i && !eof_evt_i && !crc_err_evt_i && !overrun_evt_i && !parity_evt_i)
      |=> (status_o[STAT_W-1 -: 4] == 4'b0000));

  // R7
  crc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[STAT_W-2] && !err_reset_i && !chan_reset_i) |=> status_o[STAT_W-2]);

  // R6
  residue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eof_take && !new_frame_i && !chan_reset_i) |=> $stable(status_o[RES_W:1]));

  // R9
  sent_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_CHAR) |=> status_o[0]);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_int_en_i && $rose(status_o[STAT_W-3])) |-> src_irq_o);
endmodule

// File: tb/rx_cond_status_tb_top.sv
`timescale 1ns/1ps
module rx_cond_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b10;
  logic       ien = 1'b0, eofe = 1'b0, crce = 1'b0, ovre = 1'b0, pare = 1'b0;
  logic       nfr = 1'b0, idle = 1'b0, erst = 1'b0, crst = 1'b0;
  logic [2:0] res = 3'd0;
  logic [7:0] st;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_cond_status #(.RES_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .rx_int_en_i(ien),
    .eof_evt_i(eofe), .crc_err_evt_i(crce), .overrun_evt_i(ovre),
    .parity_evt_i(pare), .new_frame_i(nfr), .residue_i(res),
    .tx_idle_i(idle), .err_reset_i(erst), .chan_reset_i(crst),
    .status_o(st), .src_irq_o(irq));

  bit m_eof, m_crc, m_ovr, m_par, m_sent;
  int m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || (rst_n && crst)) begin
      m_eof = 0; m_crc = 0; m_ovr = 0; m_par = 0; m_res = 0; m_sent = 1;
    end else begin
      bit clr_err;
      clr_err = erst;
      if (mode == 2'b10 && eofe) begin
        m_eof = 1; m_res = int'(res);
      end else if (nfr) begin
        m_eof = 0; m_res = 0;
      end else if (clr_err) m_eof = 0;
      if (crce) m_crc = 1; else if (clr_err) m_crc = 0;
      if (ovre) m_ovr = 1; else if (clr_err) m_ovr = 0;
      if (pare) m_par = 1; else if (clr_err) m_par = 0;
      if (mode == 2'b00) m_sent = idle; else m_sent = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      bit e7, any;
      e7 = m_eof && (mode == 2'b10);
      any = e7 || m_crc || m_ovr || m_par;
      chk("R1/R3/R4 bit7 end of frame", int'(st[7]), int'(e7));
      chk("R1/R7/R5 bit6 crc", int'(st[6]), int'(m_crc));
      chk("R1/R7/R5 bit5 overrun", int'(st[5]), int'(m_ovr));
      chk("R1/R7/R5 bit4 parity", int'(st[4]), int'(m_par));
      chk("R1/R3/R6 residue bits3..1", int'(st[3:1]), m_res);
      chk("R1/R9 bit0 all sent", int'(st[0]), int'(m_sent));
      chk("R8 irq", int'(irq), int'(ien && any));
    end
  end

  task automatic quiet();
    eofe = 0; crce = 0; ovre = 0; pare = 0; nfr = 0; erst = 0; crst = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    chk("R2 reset byte", int'(st), 8'h01);
    chk("R2 reset irq", int'(irq), 0);
    // R3 frame close in framed mode
    ien = 1; mode = 2'b10; eofe = 1; res = 3'd5; step(); quiet(); step();
    chk("R3 eof set value", int'(st), 8'h8B);
    // R4 masking and reappearance
    mode = 2'b01; step(); mode = 2'b00; idle = 1; step(); mode = 2'b10; step();
    // R3 ignored outside framed mode
    mode = 2'b01; eofe = 1; res = 3'd2; step(); quiet(); step(); mode = 2'b10; step();
    // R6 new frame, with and without same-cycle eof
    nfr = 1; step(); quiet(); step();
    eofe = 1; nfr = 1; res = 3'd7; step(); quiet(); step();
    // R7 sticky errors, R5 clear and priority
    crce = 1; step(); quiet(); ovre = 1; step(); quiet(); pare = 1; step(); quiet(); step();
    erst = 1; crce = 1; step(); quiet(); step();
    erst = 1; step(); quiet(); step();
    // R2 channel reset with events
    eofe = 1; crce = 1; pare = 1; step(); quiet(); crst = 1; ovre = 1; step(); quiet();
    chk("R2 channel reset byte", int'(st), 8'h01);
    step();
    // mixed stimulus
    for (int i = 0; i < 4000; i++) begin
      bit [31:0] r;
      r = $urandom;
      quiet();
      if (r[5:0] == 0) mode = r[7:6];
      eofe = (r[10:8] == 0);
      crce = (r[14:11] == 0);
      ovre = (r[18:15] == 1);
      pare = (r[22:19] == 2);
      nfr  = (r[25:23] == 3);
      erst = (r[29:26] == 4);
      crst = (r[9:0] == 10'h3ff);
      res  = r[31:29];
      idle = r[30];
      ien  = (r[2:0] != 0);
      if (i == 2000) rst_n = 0;
      if (i == 2003) rst_n = 1;
      step();
    end
    quiet();
    step(); step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule